// File: doc/BRIEF.md
# Counter Target-Match Set/Clear Unit

This unit sits beside a pulse counter and watches the signed count it produces. Each time the counter raises its update strobe, the unit compares the freshly updated count with a signed target. An event fires only when the count has just arrived at the target, so the previous count differed from it. The count may arrive from either side. Remaining on the target or stepping off it fires nothing. The test runs in the same cycle as the update, so there is no delay from any slow polling loop.

On an event the unit either drives its output bit high or drives it low, as chosen by a mode input. It also emits a single-cycle interrupt request. The unit acts only while it is enabled and the counter reports that it is running. If it is enabled while the counter is stopped, it raises an error flag and takes no action. When the unit is armed, it loads the count present at that moment as the previous count. Arming while the count already sits on the target therefore causes no false event.

Top module: `tgt_match_unit`

## Requirements
- R1: An update strobe whose count equals the target, with the previous count below the target (for example target-1 then target, or a larger jump up), raises `irq` for exactly one cycle in the cycle after the strobe's clock edge.
- R2: Arrival from above (for example target+1 then target) raises the same single-cycle `irq`.
- R3: An update that leaves the target, or that keeps the count on the target, raises no `irq` and leaves `out_bit` unchanged.
- R4: With `mode_set` = 1 at the strobe, an event drives `out_bit` to 1 from the cycle after the strobe edge.
- R5: With `mode_set` = 0 at the strobe, an event drives `out_bit` to 0 from the cycle after the strobe edge.
- R6: Without an event `out_bit` holds its value, and `irq` is low in every cycle that does not directly follow an event.
- R7: Every new return to the target after leaving it produces another `irq` pulse.
- R8: While `en` = 1 and `cnt_run` = 0, `err` is 1 from the next cycle on, and strobes cause no `irq` and no change of `out_bit`. `err` is 0 whenever `en` was 0 or `cnt_run` was 1 in the previous cycle.
- R9: On the first cycle that `en` and `cnt_run` are both high, the unit is armed and captures the current count as the previous count. A strobe in that cycle is not evaluated. If the captured count equals the target, a later update that stays on the target produces no event.
- R10: With `en` = 0, strobes produce no `irq` and no change of `out_bit`.
- R11: During reset, `out_bit` equals parameter `OUT_INIT` (default 0), and `irq` and `err` are 0.
- R12: The count is a signed 32-bit ring. The step 0x7FFFFFFF to 0x80000000 with target 0x80000000 counts as an arrival, and so does the step 0x80000000 to 0x7FFFFFFF with target 0x7FFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_val | input | CNT_W | Counter value, valid as the updated count while `cnt_upd` is high |
| cnt_upd | input | 1 | Counter update strobe |
| tgt_val | input | CNT_W | Signed target |
| mode_set | input | 1 | 1: event sets `out_bit`; 0: event clears it |
| en | input | 1 | Unit enable |
| cnt_run | input | 1 | Counter is running |
| out_bit | output | 1 | Controlled output bit |
| irq | output | 1 | One-cycle interrupt request per event |
| err | output | 1 | Enabled while the counter is stopped |

## Verification
Every result is registered once. `irq`, `out_bit` and `err` all reflect the inputs present at one clock edge, and they appear in the cycle that follows that edge. The bench therefore drives a strobe at a falling edge, lets one rising edge pass, and samples at the next falling edge. One further cycle later it checks that `irq` has dropped again. Arming takes one edge with no strobe, and the bench's model captures its previous count at that same point. Expected pulses and output levels come from a bench model that tracks the previous count, the armed state and the mode.

// File: rtl/tmu_pkg.sv
package tmu_pkg;

   typedef enum logic {
      ACT_CLEAR = 1'b0,
      ACT_SET   = 1'b1
   } act_e;

   function automatic int unsigned slice_count(input int unsigned width, input int unsigned slice);
      return (width + slice - 1) / slice;
   endfunction

endpackage

// File: rtl/tmu_eq_slices.sv
module tmu_eq_slices #(
   parameter int unsigned CNT_W   = 32,
   parameter int unsigned SLICE_W = 8
) (
   input  logic [CNT_W-1:0] a,
   input  logic [CNT_W-1:0] b,
   output logic             eq
);
   localparam int unsigned NSL = tmu_pkg::slice_count(CNT_W, SLICE_W);

   logic [NSL-1:0] sl_eq;

   initial begin
      AST_SLICE_FITS: assert (SLICE_W >= 1 && SLICE_W <= CNT_W)
         else $error("slice width must lie in 1..CNT_W"); // R1
   end

   for (genvar i = 0; i < NSL; i++) begin : g_sl
      localparam int unsigned LO = i * SLICE_W;
      localparam int unsigned HI = (LO + SLICE_W - 1 < CNT_W - 1) ? LO + SLICE_W - 1 : CNT_W - 1;
      assign sl_eq[i] = (a[HI:LO] == b[HI:LO]);
   end

   assign eq = &sl_eq;

endmodule

// File: rtl/tmu_gate.sv
module tmu_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic cnt_run,
   output logic active,
   output logic armed,
   output logic arm_pulse,
   output logic err
);
   logic armed_q;
   logic err_q;

   assign active    = en & cnt_run;
   assign arm_pulse = active & ~armed_q;
   assign armed     = armed_q;
   assign err       = err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         armed_q <= active;
         err_q   <= en & ~cnt_run;
      end
   end

   AST_ARM_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      arm_pulse |=> !arm_pulse); // R9

endmodule

// File: rtl/tmu_hit_det.sv
module tmu_hit_det #(
   parameter int unsigned CNT_W      = 32,
   parameter int unsigned SLICE_W    = 8,
   parameter bit          KEEP_COUNT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic [CNT_W-1:0] tgt_val,
   input  logic             cnt_upd,
   input  logic             active,
   input  logic             armed,
   input  logic             arm_pulse,
   output logic             hit
);
   logic eq_now;
   logic eq_prev;
   logic load;

   assign load = cnt_upd | arm_pulse;

   tmu_eq_slices #(.CNT_W(CNT_W), .SLICE_W(SLICE_W)) u_eq_now (
      .a  (cnt_val),
      .b  (tgt_val),
      .eq (eq_now)
   );

   if (KEEP_COUNT) begin : g_full
      logic [CNT_W-1:0] prev_q;
      always_ff @(posedge clk) begin
         if (!rst_n)    prev_q <= '0;
         else if (load) prev_q <= cnt_val;
      end
      tmu_eq_slices #(.CNT_W(CNT_W), .SLICE_W(SLICE_W)) u_eq_prev (
         .a  (prev_q),
         .b  (tgt_val),
         .eq (eq_prev)
      );
   end else begin : g_flag
      logic prev_eq_q;
      always_ff @(posedge clk) begin
         if (!rst_n)    prev_eq_q <= 1'b0;
         else if (load) prev_eq_q <= eq_now;
      end
      assign eq_prev = prev_eq_q;
   end

   assign hit = active & armed & cnt_upd & eq_now & ~eq_prev;

   AST_NO_REPEAT_ON_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (hit ##1 (cnt_upd && $stable(cnt_val) && $stable(tgt_val))) |-> !hit); // R3

endmodule

// File: rtl/tmu_act.sv
module tmu_act #(
   parameter bit OUT_INIT = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hit,
   input  tmu_pkg::act_e mode,
   output logic          out_bit,
   output logic          irq
);
   logic out_q;
   logic irq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_q <= OUT_INIT;
         irq_q <= 1'b0;
      end else begin
         irq_q <= hit;
         if (hit) out_q <= (mode == tmu_pkg::ACT_SET);
      end
   end

   assign out_bit = out_q;
   assign irq     = irq_q;

   AST_OUT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && mode == tmu_pkg::ACT_SET) |=> out_bit); // R4
   AST_OUT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && mode == tmu_pkg::ACT_CLEAR) |=> !out_bit); // R5
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !irq |-> $stable(out_bit)); // R6

endmodule

// File: rtl/tgt_match_unit.sv
module tgt_match_unit #(
   parameter int unsigned CNT_W      = 32,
   parameter int unsigned SLICE_W    = 8,
   parameter bit          KEEP_COUNT = 1'b1,
   parameter bit          OUT_INIT   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic             cnt_upd,
   input  logic [CNT_W-1:0] tgt_val,
   input  logic             mode_set,
   input  logic             en,
   input  logic             cnt_run,
   output logic             out_bit,
   output logic             irq,
   output logic             err
);
   logic active;
   logic armed;
   logic arm_pulse;
   logic hit;

   initial begin
      AST_WIDTH_OK: assert (CNT_W >= 2)
         else $error("count width must be at least 2"); // R12
   end

   tmu_gate u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .cnt_run   (cnt_run),
      .active    (active),
      .armed     (armed),
      .arm_pulse (arm_pulse),
      .err       (err)
   );

   tmu_hit_det #(
      .CNT_W      (CNT_W),
      .SLICE_W    (SLICE_W),
      .KEEP_COUNT (KEEP_COUNT)
   ) u_hit (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_val   (cnt_val),
      .tgt_val   (tgt_val),
      .cnt_upd   (cnt_upd),
      .active    (active),
      .armed     (armed),
      .arm_pulse (arm_pulse),
      .hit       (hit)
   );

   tmu_act #(.OUT_INIT(OUT_INIT)) u_act (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (hit),
      .mode    (tmu_pkg::act_e'(mode_set)),
      .out_bit (out_bit),
      .irq     (irq)
   );

   AST_IRQ_ON_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ($past(cnt_upd) && ($past(cnt_val) == $past(tgt_val)))); // R1
   AST_IRQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ($past(en) && $past(cnt_run))); // R8
   AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !irq); // R8
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en) |-> !irq); // R10

endmodule

// File: tb/tgt_match_unit_test.sv
module tgt_match_unit_test;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] cnt_val = '0;
   logic [W-1:0] tgt_val = '0;
   logic         cnt_upd = 1'b0;
   logic         mode_set = 1'b0;
   logic         en = 1'b0;
   logic         cnt_run = 1'b0;
   logic         out_bit;
   logic         irq;
   logic         err;

   int n_chk = 0;
   int n_err = 0;

   logic [W-1:0] prev_m = '0;
   bit           armed_m = 1'b0;
   bit           out_m = 1'b0;

   always #4 clk = ~clk;

   tgt_match_unit uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt_val  (cnt_val),
      .cnt_upd  (cnt_upd),
      .tgt_val  (tgt_val),
      .mode_set (mode_set),
      .en       (en),
      .cnt_run  (cnt_run),
      .out_bit  (out_bit),
      .irq      (irq),
      .err      (err)
   );

   task automatic check(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // drive one update strobe, sample one cycle later, then confirm the pulse ended
   task automatic upd(input logic [W-1:0] v, input string quiet_tag, output bit got);
      bit    hit;
      string rq;
      cnt_val = v;
      cnt_upd = 1'b1;
      @(negedge clk);
      cnt_upd = 1'b0;
      hit = armed_m && (v == tgt_val) && (prev_m != tgt_val);
      if (hit) begin
         out_m = mode_set;
         rq = ((tgt_val - prev_m) < 32'h8000_0000) ? "R1" : "R2";
      end else begin
         rq = quiet_tag;
      end
      prev_m = v;
      got = irq;
      check(rq, "irq", {31'b0, irq}, {31'b0, hit});
      check(hit ? (mode_set ? "R4" : "R5") : "R6", "out_bit", {31'b0, out_bit}, {31'b0, out_m});
      @(negedge clk);
      check("R6", "irq after pulse", {31'b0, irq}, '0);
   endtask

   task automatic arm();
      @(negedge clk);
      if (en && cnt_run) begin
         armed_m = 1'b1;
         prev_m  = cnt_val;
      end
   endtask

   initial begin
      #(8 * 200000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      bit got;
      int reps;
      logic [W-1:0] tlist [5];
      tlist[0] = 32'd0;
      tlist[1] = 32'd1000;
      tlist[2] = -32'sd7;
      tlist[3] = 32'h7FFF_FFFF;
      tlist[4] = 32'h8000_0000;

      // reset state
      repeat (3) @(negedge clk);
      check("R11", "out_bit in reset", {31'b0, out_bit}, '0);
      check("R11", "irq in reset", {31'b0, irq}, '0);
      check("R11", "err in reset", {31'b0, err}, '0);
      rst_n = 1'b1;
      cnt_run = 1'b1;
      @(negedge clk);
      check("R8", "err idle", {31'b0, err}, '0);

      // disabled: no events
      tgt_val = 32'd10;
      mode_set = 1'b1;
      upd(32'd9, "R10", got);
      upd(32'd10, "R10", got);
      check("R10", "out_bit disabled", {31'b0, out_bit}, '0);

      // arming on the target
      en = 1'b1;
      arm();
      upd(32'd10, "R9", got);
      upd(32'd11, "R3", got);
      upd(32'd10, "R3", got);
      check("R4", "set after return", {31'b0, out_bit}, 32'd1);

      // sweep targets, both modes, both directions
      for (int ti = 0; ti < 5; ti++) begin
         for (int m = 0; m < 2; m++) begin
            tgt_val = tlist[ti];
            mode_set = m[0];
            @(negedge clk);
            for (int d = -3; d <= 3; d++) upd(tlist[ti] + d, "R3", got);
            for (int d = 2; d >= -3; d--) upd(tlist[ti] + d, "R3", got);
            upd(tlist[ti] + 32'd1000, "R3", got);
            upd(tlist[ti], "R3", got);
         end
      end

      // ring wrap both ways
      tgt_val = 32'h8000_0000;
      mode_set = 1'b1;
      upd(32'h7FFF_FFFF, "R12", got);
      upd(32'h8000_0000, "R12", got);
      check("R12", "wrap up event", {31'b0, got}, 32'd1);
      tgt_val = 32'h7FFF_FFFF;
      mode_set = 1'b0;
      upd(32'h8000_0000, "R12", got);
      upd(32'h7FFF_FFFF, "R12", got);
      check("R12", "wrap down event", {31'b0, got}, 32'd1);

      // repeated returns
      tgt_val = 32'd50;
      reps = 0;
      for (int k = 0; k < 4; k++) begin
         mode_set = k[0];
         upd(32'd51, "R3", got);
         upd(32'd50, "R7", got);
         if (got) reps++;
         upd(32'd50, "R3", got);
      end
      check("R7", "repeat count", reps, 32'd4);

      // stopped counter while enabled
      mode_set = 1'b1;
      cnt_run = 1'b0;
      armed_m = 1'b0;
      @(negedge clk);
      check("R8", "err raised", {31'b0, err}, 32'd1);
      upd(32'd49, "R8", got);
      upd(32'd50, "R8", got);
      check("R8", "no irq while stopped", {31'b0, got}, '0);
      check("R8", "err held", {31'b0, err}, 32'd1);
      cnt_run = 1'b1;
      arm();
      check("R8", "err cleared", {31'b0, err}, '0);
      upd(32'd50, "R9", got);
      upd(32'd49, "R3", got);
      upd(32'd50, "R3", got);
      check("R4", "set after rearm", {31'b0, out_bit}, 32'd1);

      // disable again
      en = 1'b0;
      armed_m = 1'b0;
      mode_set = 1'b0;
      @(negedge clk);
      upd(32'd49, "R10", got);
      upd(32'd50, "R10", got);
      check("R10", "out_bit held when off", {31'b0, out_bit}, 32'd1);
      check("R8", "err off when disabled", {31'b0, err}, '0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule